// File: doc/BRIEF.md
# Block String Sequencer

This block executes block-memory string instructions for a processor core. It runs over many cycles and works on three working registers: a primary pointer (the destination, or the address being scanned), a secondary operand (the source pointer, the fill value or the value searched for) and an element count. The caller loads all three on a start strobe together with an operation code and an element size. The block then walks memory through one byte-addressed port until the count runs out or the operation's own stop condition is met. When the loop ends it raises a one-cycle done pulse. The updated registers and a zero flag and a carry flag stay on the outputs until the next operation.

Seven operations are supported. Three are byte copies: upward, downward, and upward stopping after a zero byte. One is a fill. Two are scans, which search for a matching element or skip over matching elements. The last is a compare of two strings that ends at a zero byte. Fill and the scans take an element size of one, two or four bytes. Copies and compare always work on single bytes.

The memory port returns read data one cycle after the read strobe. Its read data is a little-endian 4-byte window starting at the given address. A write stores the low 1, 2 or 4 bytes of the write data, as selected by the size output.

Top module: `str_seq_engine`

## Requirements
- R1: A start with a count of zero does no memory access and leaves the registers unchanged. done is high in the second cycle after the start edge.
- R2: Operation code 0 copies bytes upward. Each element reads the byte at the secondary pointer, writes it to the primary pointer, adds 1 to both pointers and subtracts 1 from the count. It ends with the count at zero.
- R3: Operation code 1 copies bytes downward. It works like R2 but subtracts 1 from both pointers.
- R4: Operation code 2 copies bytes upward like R2. It also ends right after an element whose byte is zero, and the pointers and count are updated for that element.
- R5: Operation code 3 writes the low 1, 2 or 4 bytes of the secondary operand at the primary pointer, for size codes 0, 1 and 2. After each write the primary pointer advances by the element size. The secondary operand is left unchanged.
- R6: Operation code 4 reads zero-extended elements at the primary pointer, advances it by the size and subtracts 1 from the count. It ends when an element equals the secondary operand. Z is set when the last element equals the operand. C is set when the last element is at most the operand, unsigned.
- R7: Operation code 5 scans like R6 but ends when an element differs from the operand. Z is set when the remaining count is zero. C is set when the last element is at most the operand.
- R8: Operation code 6 reads byte x at the primary pointer and byte y at the secondary pointer, then adds 1 to both pointers. It ends on x differing from y or on x being zero. Z is set when x equals y. C is set when x is at least y, unsigned.
- R9: The flags change only in a scan or compare that handles at least one element. A scan or compare started with a zero count leaves both flags unchanged.
- R10: A start with size code 3 or operation code 7 is refused: err pulses high one cycle after the start edge. busy and done stay low, there is no memory access, and the registers are unchanged.
- R11: The port never reads and writes in the same cycle and is quiet while idle. Each element uses exactly: one read and one write for copies, one write for fill, one read for scans, two reads for compare.
- R12: busy is high from the cycle after an accepted start through the done cycle. done lasts one cycle, after which busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation code 0..6, 7 reserved |
| size | input | 2 | Element size code: 0 byte, 1 halfword, 2 word, 3 illegal |
| ptr_a_in | input | XW | Initial primary pointer |
| ptr_b_in | input | XW | Initial secondary pointer or operand |
| cnt_in | input | XW | Initial element count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | One-cycle refused-start pulse |
| ptr_a | output | XW | Current primary pointer |
| ptr_b | output | XW | Current secondary pointer or operand |
| cnt | output | XW | Current element count |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | XW | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | XW | Write data, low bytes used |
| mem_rdata | input | XW | Read data, valid one cycle after mem_rd |

## Verification
Each copy runs over byte patterns in which no two neighbours are equal. Any pointer-direction or off-by-one error therefore shows up in the memory image. The zero-stopping copy and the compare are given a zero byte partway through, so an early or late stop changes the final count. Scans are tried with a hit, with no hit, and with every element matching. These separate the three flag rules and show which element the flags come from. The compare uses equal strings, a larger first byte and a smaller first byte, and then a zero-count scan checks that the flags from those runs survive.

// File: rtl/str_eng_pkg.sv
package str_eng_pkg;

  typedef enum logic [2:0] {
    OP_CPY_UP   = 3'd0,
    OP_CPY_DOWN = 3'd1,
    OP_CPY_Z    = 3'd2,
    OP_FILL     = 3'd3,
    OP_SEEK     = 3'd4,
    OP_SKIP     = 3'd5,
    OP_CMP      = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD2,
    ST_WR,
    ST_EV,
    ST_FIN
  } st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  function automatic logic is_copy(input op_e o);
    return (o == OP_CPY_UP) || (o == OP_CPY_DOWN) || (o == OP_CPY_Z);
  endfunction

  function automatic logic is_sized(input op_e o);
    return (o == OP_FILL) || (o == OP_SEEK) || (o == OP_SKIP);
  endfunction

endpackage

// File: rtl/str_eng_step.sv
module str_eng_step #(
  parameter int XW = 32
) (
  input  logic [1:0]    size,
  input  logic          backward,
  output logic [XW-1:0] delta
);
  localparam logic [XW-1:0] ONE = XW'(1);

  always_comb begin
    if (backward) delta = '1;
    else          delta = ONE << size;
  end
endmodule

// File: rtl/str_eng_eval.sv
module str_eng_eval
  import str_eng_pkg::*;
#(
  parameter int XW = 32
) (
  input  op_e           op,
  input  logic [1:0]    size,
  input  logic [XW-1:0] rdata,
  input  logic [7:0]    first_byte,
  input  logic [XW-1:0] key,
  input  logic [XW-1:0] cnt_next,
  output logic          stop,
  output logic          z,
  output logic          c
);
  localparam logic [XW-1:0] MASK_B = XW'(8'hFF);
  localparam logic [XW-1:0] MASK_H = XW'(16'hFFFF);

  logic [XW-1:0] mask;
  logic [XW-1:0] elem;
  logic [7:0]    second_byte;
  logic          last;

  always_comb begin
    case (size)
      2'd0:    mask = MASK_B;
      2'd1:    mask = MASK_H;
      default: mask = '1;
    endcase
  end

  assign elem        = rdata & mask;
  assign second_byte = rdata[7:0];
  assign last        = (cnt_next == '0);

  always_comb begin
    stop = last;
    z    = 1'b0;
    c    = 1'b0;
    case (op)
      OP_SEEK: begin
        stop = last || (elem == key);
        z    = (elem == key);
        c    = (elem <= key);
      end
      OP_SKIP: begin
        stop = last || (elem != key);
        z    = last;
        c    = (elem <= key);
      end
      OP_CMP: begin
        stop = last || (first_byte != second_byte) || (first_byte == 8'd0);
        z    = (first_byte == second_byte);
        c    = (first_byte >= second_byte);
      end
      OP_CPY_Z: begin
        stop = last || (second_byte == 8'd0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/str_eng_ctrl.sv
module str_eng_ctrl
  import str_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  op_e        op_in,
  input  logic [1:0] size_in,
  input  logic       cnt_zero_in,
  input  op_e        op_q,
  input  logic       stop,
  output st_e        state,
  output logic       accept,
  output logic       reject
);
  st_e  nxt;
  logic bad;

  assign bad    = (size_in == SZ_BAD) || (op_in == OP_RSVD);
  assign accept = (state == ST_IDLE) && start && !bad;
  assign reject = (state == ST_IDLE) && start && bad;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (cnt_zero_in)          nxt = ST_FIN;
          else if (op_in == OP_FILL) nxt = ST_WR;
          else                       nxt = ST_RD;
        end
      end
      ST_RD: begin
        if (op_q == OP_CMP)    nxt = ST_RD2;
        else if (is_copy(op_q)) nxt = ST_WR;
        else                    nxt = ST_EV;
      end
      ST_RD2: nxt = ST_EV;
      ST_WR: begin
        if (stop)                 nxt = ST_FIN;
        else if (op_q == OP_FILL) nxt = ST_WR;
        else                      nxt = ST_RD;
      end
      ST_EV:   nxt = stop ? ST_FIN : ST_RD;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/str_seq_engine.sv
module str_seq_engine
  import str_eng_pkg::*;
#(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [1:0]    size,
  input  logic [XW-1:0] ptr_a_in,
  input  logic [XW-1:0] ptr_b_in,
  input  logic [XW-1:0] cnt_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [XW-1:0] ptr_a,
  output logic [XW-1:0] ptr_b,
  output logic [XW-1:0] cnt,
  output logic          flag_z,
  output logic          flag_c,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [XW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [XW-1:0] mem_wdata,
  input  logic [XW-1:0] mem_rdata
);
  localparam logic [XW-1:0] ONE = XW'(1);

  st_e           state;
  op_e           op_q;
  logic [1:0]    size_q;
  logic [1:0]    size_eff;
  logic [7:0]    first_q;
  logic          err_q;
  logic          accept;
  logic          reject;
  logic          stop;
  logic          ev_z;
  logic          ev_c;
  logic [XW-1:0] delta;
  logic [XW-1:0] cnt_next;

  assign cnt_next = cnt - ONE;
  assign size_eff = is_sized(op_q) ? size_q : SZ_BYTE;

  str_eng_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .op_in       (op_e'(op)),
    .size_in     (size),
    .cnt_zero_in (cnt_in == '0),
    .op_q        (op_q),
    .stop        (stop),
    .state       (state),
    .accept      (accept),
    .reject      (reject)
  );

  str_eng_step #(.XW(XW)) u_step (
    .size     (size_eff),
    .backward (op_q == OP_CPY_DOWN),
    .delta    (delta)
  );

  str_eng_eval #(.XW(XW)) u_eval (
    .op         (op_q),
    .size       (size_eff),
    .rdata      (mem_rdata),
    .first_byte (first_q),
    .key        (ptr_b),
    .cnt_next   (cnt_next),
    .stop       (stop),
    .z          (ev_z),
    .c          (ev_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_CPY_UP;
      size_q  <= SZ_BYTE;
      ptr_a   <= '0;
      ptr_b   <= '0;
      cnt     <= '0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
      first_q <= 8'd0;
      err_q   <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept) begin
        op_q   <= op_e'(op);
        size_q <= size;
        ptr_a  <= ptr_a_in;
        ptr_b  <= ptr_b_in;
        cnt    <= cnt_in;
      end
      case (state)
        ST_RD2: first_q <= mem_rdata[7:0];
        ST_WR: begin
          ptr_a <= ptr_a + delta;
          if (is_copy(op_q)) ptr_b <= ptr_b + delta;
          cnt <= cnt_next;
        end
        ST_EV: begin
          ptr_a <= ptr_a + delta;
          if (op_q == OP_CMP) ptr_b <= ptr_b + delta;
          cnt    <= cnt_next;
          flag_z <= ev_z;
          flag_c <= ev_c;
        end
        default: ;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
  assign err  = err_q;

  assign mem_rd   = (state == ST_RD) || (state == ST_RD2);
  assign mem_wr   = (state == ST_WR);
  assign mem_size = size_eff;

  always_comb begin
    case (state)
      ST_RD:   mem_addr = is_copy(op_q) ? ptr_b : ptr_a;
      ST_RD2:  mem_addr = ptr_b;
      default: mem_addr = ptr_a;
    endcase
  end

  assign mem_wdata = (op_q == OP_FILL) ? ptr_b : {{(XW-8){1'b0}}, mem_rdata[7:0]};

endmodule

// File: rtl/str_seq_engine_chk.sv
module str_seq_engine_chk #(
  parameter int XW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          flag_z,
  input logic          flag_c,
  input logic [XW-1:0] cnt
);
  // R11: one port, one direction per cycle
  a_r11_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R11: quiet port while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_rd || mem_wr));

  // R12: done is a single-cycle pulse
  a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12: done only while busy
  a_r12_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R10: refused start leaves the engine idle
  a_r10_err_idle: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !done));

  // R9: flags never move while idle
  a_r9_flags_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(flag_z) && $stable(flag_c)));

  // R2: count never rises inside an operation
  a_r2_count_non_increasing: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (cnt <= $past(cnt)));
endmodule

bind str_seq_engine str_seq_engine_chk #(.XW(XW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .flag_z (flag_z),
  .flag_c (flag_c),
  .cnt    (cnt)
);

// File: tb/test_str_seq_engine.sv
module test_str_seq_engine;
  localparam int XW = 32;
  localparam int MB = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    op = '0;
  logic [1:0]    size = '0;
  logic [XW-1:0] ptr_a_in = '0, ptr_b_in = '0, cnt_in = '0;
  logic          busy, done, err, flag_z, flag_c, mem_rd, mem_wr;
  logic [XW-1:0] ptr_a, ptr_b, cnt, mem_addr, mem_wdata;
  logic [XW-1:0] mem_rdata = '0;
  logic [1:0]    mem_size;

  always #2 clk = ~clk;

  str_seq_engine #(.XW(XW)) i_str_seq_engine (
    .clk(clk), .rst(rst), .start(start), .op(op), .size(size),
    .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in), .cnt_in(cnt_in),
    .busy(busy), .done(done), .err(err),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .cnt(cnt),
    .flag_z(flag_z), .flag_c(flag_c),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem     [0:MB-1];
  logic [7:0] ref_mem [0:MB-1];

  always @(posedge clk) begin
    if (mem_rd)
      mem_rdata <= {mem[mem_addr[9:0] + 10'd3], mem[mem_addr[9:0] + 10'd2],
                    mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};
    if (mem_wr) begin
      mem[mem_addr[9:0]] <= mem_wdata[7:0];
      if (mem_size != 2'd0) mem[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
      if (mem_size == 2'd2) begin
        mem[mem_addr[9:0] + 10'd2] <= mem_wdata[23:16];
        mem[mem_addr[9:0] + 10'd3] <= mem_wdata[31:24];
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int rd_seen = 0;
  int wr_seen = 0;

  always @(posedge clk) begin
    if (mem_rd) rd_seen++;
    if (mem_wr) wr_seen++;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [XW-1:0] act, input logic [XW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic          is_err;
    logic [XW-1:0] a;
    logic [XW-1:0] b;
    logic [XW-1:0] n;
    logic          z;
    logic          c;
    logic [15:0]   rd;
    logic [15:0]   wr;
  } item_t;

  item_t q[$];
  string tq[$];

  logic [XW-1:0] ea = '0, eb = '0, en = '0;
  logic          ez = 1'b0, ec = 1'b0;

  function automatic logic [XW-1:0] ref_elem(input logic [XW-1:0] ad, input logic [1:0] sz);
    logic [9:0] i;
    i = ad[9:0];
    case (sz)
      2'd0:    return {24'd0, ref_mem[i]};
      2'd1:    return {16'd0, ref_mem[i + 10'd1], ref_mem[i]};
      default: return {ref_mem[i + 10'd3], ref_mem[i + 10'd2], ref_mem[i + 10'd1], ref_mem[i]};
    endcase
  endfunction

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (!rst && (done || err)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R12", "unexpected completion", '0, '0);
      end else begin
        item_t it;
        string tg;
        it = q.pop_front();
        tg = tq.pop_front();
        chk(err == it.is_err, tg, "err vs done", err, it.is_err);
        chk(ptr_a == it.a, tg, "primary pointer", ptr_a, it.a);
        chk(ptr_b == it.b, tg, "secondary operand", ptr_b, it.b);
        chk(cnt == it.n, tg, "count", cnt, it.n);
        chk(flag_z == it.z, tg, "Z flag", flag_z, it.z);
        chk(flag_c == it.c, tg, "C flag", flag_c, it.c);
        chk(rd_seen == int'(it.rd), "R11", "read cycles", rd_seen, it.rd);
        chk(wr_seen == int'(it.wr), "R11", "write cycles", wr_seen, it.wr);
      end
    end
  end

  task automatic put(input int ad, input logic [7:0] v);
    mem[ad] = v;
    ref_mem[ad] = v;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [1:0] sz,
                        input logic [XW-1:0] a, input logic [XW-1:0] b,
                        input logic [XW-1:0] n, input string tg);
    item_t it;
    int k;
    logic [XW-1:0] e;
    logic [7:0] x, y;
    int bad_bytes;
    k = 0; e = '0; x = 0; y = 0;
    it = '0;
    if (sz == 2'd3 || o == 3'd7) begin
      it.is_err = 1'b1;
    end else begin
      ea = a; eb = b; en = n;
      while (en != 0) begin
        k++;
        if (o <= 3'd2) begin
          x = ref_mem[eb[9:0]];
          ref_mem[ea[9:0]] = x;
          ea = (o == 3'd1) ? ea - 1 : ea + 1;
          eb = (o == 3'd1) ? eb - 1 : eb + 1;
          en--;
          if (o == 3'd2 && x == 8'd0) break;
        end else if (o == 3'd3) begin
          ref_mem[ea[9:0]] = eb[7:0];
          if (sz != 0) ref_mem[ea[9:0] + 10'd1] = eb[15:8];
          if (sz == 2) begin
            ref_mem[ea[9:0] + 10'd2] = eb[23:16];
            ref_mem[ea[9:0] + 10'd3] = eb[31:24];
          end
          ea = ea + (32'd1 << sz);
          en--;
        end else if (o == 3'd4 || o == 3'd5) begin
          e = ref_elem(ea, sz);
          ea = ea + (32'd1 << sz);
          en--;
          if (o == 3'd4 && e == eb) break;
          if (o == 3'd5 && e != eb) break;
        end else begin
          x = ref_mem[ea[9:0]];
          y = ref_mem[eb[9:0]];
          ea++; eb++; en--;
          if (x != y || x == 8'd0) break;
        end
      end
      if (k != 0) begin
        if (o == 3'd4) begin ez = (e == eb); ec = (e <= eb); end
        if (o == 3'd5) begin ez = (en == 0); ec = (e <= eb); end
        if (o == 3'd6) begin ez = (x == y);  ec = (x >= y);  end
      end
      case (o)
        3'd0, 3'd1, 3'd2: begin it.rd = 16'(k); it.wr = 16'(k); end
        3'd3:             it.wr = 16'(k);
        3'd6:             it.rd = 16'(2 * k);
        default:          it.rd = 16'(k);
      endcase
    end
    it.a = ea; it.b = eb; it.n = en; it.z = ez; it.c = ec;
    q.push_back(it);
    tq.push_back(tg);
    rd_seen = 0;
    wr_seen = 0;
    op = o; size = sz; ptr_a_in = a; ptr_b_in = b; cnt_in = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (it.is_err) chk(err == 1'b1 && busy == 1'b0, "R10", "err one cycle after start", err, 1);
    if (!it.is_err && n == 0) chk(done == 1'b1, "R1", "done in second cycle", done, 1);
    if (!it.is_err && n != 0) chk(busy == 1'b1, "R12", "busy after start", busy, 1);
    while (!(done || err)) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy && !err, "R12", "pulse ends, idle", {done, busy, err}, 0);
    bad_bytes = 0;
    for (int i = 0; i < MB; i++) if (mem[i] !== ref_mem[i]) bad_bytes++;
    chk(bad_bytes == 0, tg, "memory image bytes differing", bad_bytes, 0);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < MB; i++) put(i, 8'((i * 7 + 3) % 251 + 1));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !mem_rd && !mem_wr, "R12", "idle after reset",
        {busy, done, err, mem_rd, mem_wr}, 0);
    chk(ptr_a == 0 && cnt == 0 && !flag_z && !flag_c, "R12", "cleared registers after reset",
        ptr_a, 0);

    run_op(3'd0, 2'd0, 32'h200, 32'h100, 32'd0, "R1");
    run_op(3'd0, 2'd0, 32'h200, 32'h100, 32'd16, "R2");
    run_op(3'd1, 2'd0, 32'h2FF, 32'h1FF, 32'd8, "R3");
    put(32'h105, 8'd0);
    run_op(3'd2, 2'd0, 32'h300, 32'h100, 32'd20, "R4");
    run_op(3'd2, 2'd0, 32'h320, 32'h108, 32'd5, "R4");
    run_op(3'd3, 2'd0, 32'h380, 32'hA1B2C3D4, 32'd3, "R5");
    run_op(3'd3, 2'd1, 32'h390, 32'hA1B2C3D4, 32'd3, "R5");
    run_op(3'd3, 2'd2, 32'h3A0, 32'hA1B2C3D4, 32'd3, "R5");
    for (int i = 32'hC0; i < 32'hC8; i++) put(i, 8'h55);
    put(32'hC8, 8'h66);
    run_op(3'd4, 2'd0, 32'hBC, 32'h55, 32'd10, "R6");
    run_op(3'd4, 2'd1, 32'h3A0, 32'hFFFF, 32'd4, "R6");
    run_op(3'd4, 2'd2, 32'h3A0, 32'hA1B2C3D4, 32'd3, "R6");
    run_op(3'd5, 2'd0, 32'hC0, 32'h55, 32'd12, "R7");
    run_op(3'd5, 2'd0, 32'hC0, 32'h55, 32'd8, "R7");
    run_op(3'd5, 2'd1, 32'hC0, 32'h5555, 32'd6, "R7");
    put(32'h40, "a"); put(32'h41, "b"); put(32'h42, "c"); put(32'h43, 8'd0);
    put(32'h50, "a"); put(32'h51, "b"); put(32'h52, "c"); put(32'h53, 8'd0);
    put(32'h60, "a"); put(32'h61, "b"); put(32'h62, "d");
    run_op(3'd6, 2'd0, 32'h40, 32'h50, 32'd10, "R8");
    run_op(3'd6, 2'd0, 32'h60, 32'h50, 32'd10, "R8");
    run_op(3'd6, 2'd0, 32'h50, 32'h60, 32'd10, "R8");
    run_op(3'd6, 2'd0, 32'h40, 32'h50, 32'd2, "R8");
    run_op(3'd6, 2'd0, 32'h50, 32'h60, 32'd10, "R8");
    run_op(3'd4, 2'd0, 32'h40, 32'h61, 32'd0, "R9");
    run_op(3'd6, 2'd0, 32'h40, 32'h40, 32'd0, "R9");
    run_op(3'd3, 2'd3, 32'h10, 32'h20, 32'd4, "R10");
    run_op(3'd7, 2'd0, 32'h10, 32'h20, 32'd4, "R10");
    report();
  end
endmodule